// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the device side of a byte-wide non-volatile memory that sits on a four-wire serial bus. It holds 2048 bytes in a register array and runs on a fast system clock. It synchronises the serial clock, the serial input and the active-low select, and it drives a serial output together with an output-enable for a tri-state pad. Each selected frame begins with a one-byte opcode. For array commands, two address bytes follow. The frame then carries data in or data out, most significant bit first.

Writes are staged in a 32-byte page buffer. A write commits only when the select is released exactly on a byte boundary. It is then copied into the array during a self-timed busy period of `WRITE_CYCLES` system clocks. The status byte is the only thing a host can read while that period runs. The status byte holds the busy flag, the write-enable latch and two block-protect bits.

The controller is a single state machine. `WAIT_DESEL` is the state after reset; it moves to `IDLE` once the select is seen high. A select fall moves `IDLE` to `OPCODE`. After the opcode byte, `OPCODE` goes to one of five states: `ADDR` for array commands, `RSTAT` for a status read, `WSTAT` for a status write, `CMD_END` for the enable and disable commands, or `IGNORE` for unknown or refused opcodes. `ADDR` goes to `WDATA` or `RDATA` after the last address byte. `WSTAT` goes to `CMD_END` after its data byte. `CMD_END` goes to `IGNORE` if any further bit arrives. A select rise returns every selected state to `IDLE`.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset the output-enable is low and the status byte reads 0x00. The status layout is bit 0 busy, bit 1 write-enable latch, bits 3:2 block protect, and all other bits zero.
- R2: Whenever the select is high, the output-enable is low and any frame in progress is abandoned.
- R3: A frame is ignored if the select was already low when reset was released. The first command is accepted only after the select has been high and then falls.
- R4: Opcode, address and data bits are taken MSB first on rising serial-clock edges. Output bits change after falling edges. Both clock idle-low (mode 0) and idle-high (mode 3) hosts are served.
- R5: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each takes effect only if the select rises after exactly eight bits.
- R6: Opcode 0x02 followed by a 16-bit address and data bytes is a page write. It is refused unless the latch is set. Bytes land at successive columns of the addressed 32-byte page and wrap within it, and a later byte replaces an earlier one.
- R7: A page write or status write executes only if the select rises right after a complete data byte. Any other bit count leaves the array, the protect bits and the latch unchanged.
- R8: An executed write sets busy when the select rises. Busy lasts `WRITE_CYCLES` clocks, and at its end both busy and the latch clear.
- R9: Opcode 0x03 followed by an address streams bytes from that address upward and wraps from 0x7FF to 0x000.
- R10: Opcode 0x05 returns the live status byte and repeats it for as long as clocks continue, including while busy.
- R11: While busy, every opcode other than 0x05 is ignored: there is no read output, no latch change and no write.
- R12: An opcode outside the six listed makes the rest of the frame ignored up to the select rise.
- R13: Opcode 0x01 with one data byte copies data bits 3:2 into the protect bits. It requires the latch and starts a busy period. Protect value 1 guards 0x600-0x7FF, value 2 guards 0x400-0x7FF and value 3 guards the whole array. A page write into a guarded page is discarded and the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low device select |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | High when spi_miso should be driven onto the bus |

## Verification
The end of a busy period and the reload of the status shift register during a repeated status read can fall in the same system cycle. If they did not agree, a host could capture a byte with busy clear but the latch still set. The bench starts a page write and at once streams fourteen status bytes in a single frame, so that the busy expiry lands between two reloads. Every byte must be 0x03 or 0x00, the sequence may not return to 0x03 once it reads 0x00, and it must begin at 0x03 and end at 0x00.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_WAIT_DESEL,
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_WSTAT,
        ST_RDATA,
        ST_RSTAT,
        ST_CMD_END,
        ST_IGNORE
    } eep_state_e;

    typedef enum logic [1:0] {
        END_NONE,
        END_SET_WEL,
        END_CLR_WEL,
        END_WR_STAT
    } eep_end_e;

    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_RD_MEM  = 8'h03;
    localparam logic [7:0] OP_WR_MEM  = 8'h02;

endpackage

// File: rtl/eep_sync_bus.sv
module eep_sync_bus #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
        end else begin
            pipe_q[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clear) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) slot_q[wr_idx] <= wr_data;
    end

    assign rd_data   = slot_q[rd_idx];
    assign rd_valid  = mask_q[rd_idx];
    assign any_valid = |mask_q;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cell_q[wr_addr] <= wr_data;
    end

    assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
    import eep_pkg::*;
#(
    parameter int MEM_BYTES    = 2048,
    parameter int PAGE_BYTES   = 32,
    parameter int ADDR_BYTES   = 2,
    parameter int WRITE_CYCLES = 5000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic spi_cs_n,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - PAGE_W;
    localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);
    localparam int ABC_W  = $clog2(ADDR_BYTES + 1);

    // synchronised pins: [2] select, [1] clock, [0] data in
    logic [2:0] pins_s;
    logic       cs_lvl, sck_lvl, mosi_lvl;
    logic       cs_prev_q, sck_prev_q;
    logic       cs_rise, cs_fall, sck_rise_ev, sck_fall_ev, byte_done;

    eep_state_e state_q, state_d;
    eep_end_e   end_act_q;
    logic [2:0]        bitcnt_q;
    logic [6:0]        shin_q;
    logic [7:0]        shout_q, rx_byte, status_now;
    logic              miso_q;
    logic [ABC_W-1:0]  abyte_q;
    logic [ADDR_W-1:0] addr_q, addr_cat, mem_rd_addr, mem_wr_addr;
    logic [BASE_W-1:0] page_q;
    logic              is_write_q, wel_q, busy_q, commit_q;
    logic [1:0]        bp_q, stat_new_q;
    logic [BUSY_W-1:0] busy_cnt_q;
    logic [7:0]        mem_rd_data, buf_rd_data;
    logic              buf_clear, buf_wr, buf_rd_valid, buf_any, mem_wr_en;

    eep_sync_bus #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_sck, spi_mosi}),
        .dout (pins_s)
    );

    assign cs_lvl      = pins_s[2];
    assign sck_lvl     = pins_s[1];
    assign mosi_lvl    = pins_s[0];
    assign cs_rise     = cs_lvl & ~cs_prev_q;
    assign cs_fall     = ~cs_lvl & cs_prev_q;
    assign sck_rise_ev = ~cs_lvl & sck_lvl & ~sck_prev_q;
    assign sck_fall_ev = ~cs_lvl & ~sck_lvl & sck_prev_q;
    assign byte_done   = sck_rise_ev & (bitcnt_q == 3'd7);
    assign rx_byte     = {shin_q, mosi_lvl};
    assign status_now  = {4'b0000, bp_q, wel_q, busy_q};
    assign addr_cat    = ADDR_W'({addr_q, rx_byte});
    assign mem_rd_addr = (state_q == ST_ADDR) ? addr_cat : addr_q;

    function automatic logic guarded(input logic [ADDR_W-1:0] a, input logic [1:0] bp);
        unique case (bp)
            2'd0:    guarded = 1'b0;
            2'd1:    guarded = &a[ADDR_W-1 -: 2];
            2'd2:    guarded = a[ADDR_W-1];
            default: guarded = 1'b1;
        endcase
    endfunction

    // page staging and array
    assign buf_clear = (state_q == ST_OPCODE) & byte_done & (rx_byte == OP_WR_MEM);
    assign buf_wr    = (state_q == ST_WDATA) & byte_done;
    assign mem_wr_en = busy_q & commit_q & (busy_cnt_q < BUSY_W'(PAGE_BYTES)) & buf_rd_valid;
    assign mem_wr_addr = {page_q, busy_cnt_q[PAGE_W-1:0]};

    eep_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(8)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (buf_clear),
        .wr_en    (buf_wr),
        .wr_idx   (addr_q[PAGE_W-1:0]),
        .wr_data  (rx_byte),
        .rd_idx   (busy_cnt_q[PAGE_W-1:0]),
        .rd_data  (buf_rd_data),
        .rd_valid (buf_rd_valid),
        .any_valid(buf_any)
    );

    eep_array #(.DEPTH(MEM_BYTES), .DATA_W(8)) u_mem (
        .clk    (clk),
        .wr_en  (mem_wr_en),
        .wr_addr(mem_wr_addr),
        .wr_data(buf_rd_data),
        .rd_addr(mem_rd_addr),
        .rd_data(mem_rd_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_DESEL: if (cs_lvl) state_d = ST_IDLE;
            ST_IDLE:       if (cs_fall) state_d = ST_OPCODE;
            ST_OPCODE: begin
                if (byte_done) begin
                    if (busy_q && rx_byte != OP_RD_STAT) begin
                        state_d = ST_IGNORE;
                    end else begin
                        unique case (rx_byte)
                            OP_SET_WEL, OP_CLR_WEL: state_d = ST_CMD_END;
                            OP_RD_STAT:             state_d = ST_RSTAT;
                            OP_WR_STAT:             state_d = wel_q ? ST_WSTAT : ST_IGNORE;
                            OP_RD_MEM:              state_d = ST_ADDR;
                            OP_WR_MEM:              state_d = wel_q ? ST_ADDR : ST_IGNORE;
                            default:                state_d = ST_IGNORE;
                        endcase
                    end
                end
            end
            ST_ADDR: begin
                if (byte_done && abyte_q == ABC_W'(ADDR_BYTES - 1))
                    state_d = is_write_q ? ST_WDATA : ST_RDATA;
            end
            ST_WSTAT:   if (byte_done) state_d = ST_CMD_END;
            ST_CMD_END: if (sck_rise_ev) state_d = ST_IGNORE;
            ST_WDATA, ST_RDATA, ST_RSTAT, ST_IGNORE: state_d = state_q;
            default:    state_d = ST_IDLE;
        endcase
        if (cs_rise && state_q != ST_WAIT_DESEL) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_DESEL;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev_q  <= 1'b0;
            sck_prev_q <= 1'b0;
            bitcnt_q   <= '0;
            shin_q     <= '0;
            shout_q    <= '0;
            miso_q     <= 1'b0;
            abyte_q    <= '0;
            addr_q     <= '0;
            page_q     <= '0;
            is_write_q <= 1'b0;
            end_act_q  <= END_NONE;
            stat_new_q <= '0;
            wel_q      <= 1'b0;
            bp_q       <= '0;
            busy_q     <= 1'b0;
            commit_q   <= 1'b0;
            busy_cnt_q <= '0;
        end else begin
            cs_prev_q  <= cs_lvl;
            sck_prev_q <= sck_lvl;

            if (cs_lvl)           bitcnt_q <= '0;
            else if (sck_rise_ev) bitcnt_q <= bitcnt_q + 3'd1;
            if (sck_rise_ev) shin_q <= {shin_q[5:0], mosi_lvl};

            if (sck_fall_ev && (state_q == ST_RDATA || state_q == ST_RSTAT)) begin
                miso_q  <= shout_q[7];
                shout_q <= {shout_q[6:0], 1'b0};
            end

            if (byte_done) begin
                unique case (state_q)
                    ST_OPCODE: begin
                        is_write_q <= (rx_byte == OP_WR_MEM);
                        abyte_q    <= '0;
                        end_act_q  <= (rx_byte == OP_SET_WEL) ? END_SET_WEL :
                                      (rx_byte == OP_CLR_WEL) ? END_CLR_WEL : END_NONE;
                        if (rx_byte == OP_RD_STAT) shout_q <= status_now;
                    end
                    ST_ADDR: begin
                        abyte_q <= abyte_q + ABC_W'(1);
                        if (abyte_q == ABC_W'(ADDR_BYTES - 1) && !is_write_q) begin
                            shout_q <= mem_rd_data;
                            addr_q  <= addr_cat + ADDR_W'(1);
                        end else begin
                            addr_q  <= addr_cat;
                        end
                    end
                    ST_WDATA: addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
                    ST_RDATA: begin
                        shout_q <= mem_rd_data;
                        addr_q  <= addr_q + ADDR_W'(1);
                    end
                    ST_RSTAT: shout_q <= status_now;
                    ST_WSTAT: begin
                        stat_new_q <= rx_byte[3:2];
                        end_act_q  <= END_WR_STAT;
                    end
                    default: ;
                endcase
            end

            if (busy_q) begin
                busy_cnt_q <= busy_cnt_q + BUSY_W'(1);
                if (busy_cnt_q == BUSY_W'(WRITE_CYCLES - 1)) begin
                    busy_q   <= 1'b0;
                    wel_q    <= 1'b0;
                    commit_q <= 1'b0;
                end
            end

            if (cs_rise) begin
                if (state_q == ST_CMD_END) begin
                    unique case (end_act_q)
                        END_SET_WEL: wel_q <= 1'b1;
                        END_CLR_WEL: wel_q <= 1'b0;
                        END_WR_STAT: begin
                            bp_q       <= stat_new_q;
                            busy_q     <= 1'b1;
                            commit_q   <= 1'b0;
                            busy_cnt_q <= '0;
                        end
                        default: ;
                    endcase
                end else if (state_q == ST_WDATA && bitcnt_q == 3'd0 && buf_any
                             && !guarded(addr_q, bp_q)) begin
                    busy_q     <= 1'b1;
                    commit_q   <= 1'b1;
                    busy_cnt_q <= '0;
                    page_q     <= addr_q[ADDR_W-1:PAGE_W];
                end
            end
        end
    end

    assign spi_miso    = miso_q;
    assign spi_miso_oe = ~cs_lvl & (state_q == ST_RDATA || state_q == ST_RSTAT);

endmodule

// File: rtl/eep_engine_checks.sv
module eep_engine_checks
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_pin,
    input logic       miso_oe,
    input eep_state_e state,
    input logic       busy,
    input logic       wel,
    input logic       cs_rise
);
    // R2: a select held high for several clocks silences the output
    a_r2_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_pin && $past(cs_n_pin) && $past(cs_n_pin, 2) && $past(cs_n_pin, 3)) |-> !miso_oe);

    // R3: opcode capture only ever begins from the idle state
    a_r3_opcode_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPCODE && $past(state) != ST_OPCODE) |-> $past(state) == ST_IDLE);

    // R8: busy begins only on a select release
    a_r8_busy_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    // R8: the latch is clear when busy ends
    a_r8_latch_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R11: no array or status-write phase while busy
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(state == ST_ADDR || state == ST_WDATA || state == ST_RDATA || state == ST_WSTAT));

    // R6: write data is only collected with the latch set
    a_r6_wdata_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WDATA |-> wel);
endmodule

bind spi_eeprom_engine eep_engine_checks u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_pin(spi_cs_n),
    .miso_oe (spi_miso_oe),
    .state   (state_q),
    .busy    (busy_q),
    .wel     (wel_q),
    .cs_rise (cs_rise)
);

// File: tb/spi_eeprom_engine_test.sv
`timescale 1ns/1ps
module spi_eeprom_engine_test;
    localparam int WR_CYC = 1200;
    localparam int HALF   = 6;

    logic clk = 1'b0;
    logic rst_n, spi_sck, spi_mosi, spi_cs_n;
    logic spi_miso, spi_miso_oe;
    int   n_chk = 0, n_bad = 0;
    logic mode3 = 1'b0;
    logic oe_seen;
    logic [7:0] exp_mem [2048];

    always #2.5 clk = ~clk;

    spi_eeprom_engine #(.WRITE_CYCLES(WR_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            spi_sck = 1'b0; spi_mosi = tx[i];
            wclk(HALF);
            rx[i] = spi_miso;
            if (spi_miso_oe) oe_seen = 1'b1;
            spi_sck = 1'b1;
            wclk(HALF);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic sel();
        spi_sck = mode3; wclk(4);
        spi_cs_n = 1'b0; oe_seen = 1'b0; wclk(8);
    endtask

    task automatic desel();
        if (!mode3 && spi_sck) begin spi_sck = 1'b0; wclk(HALF); end
        spi_cs_n = 1'b1; wclk(12);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h01, d); xfer(v, d); desel();
    endtask

    task automatic wait_ready();
        wclk(WR_CYC + 50);
    endtask

    task automatic wr_mem(input logic [15:0] a, input int n, input logic [7:0] seed, input bit exec);
        logic [7:0] d;
        sel(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
        for (int k = 0; k < n; k++) begin
            xfer(seed + 8'(k), d);
            if (exec) exp_mem[{a[10:5], 5'(a[4:0] + 5'(k))}] = seed + 8'(k);
        end
        desel();
    endtask

    task automatic rd_chk(input logic [15:0] a, input int n, input string req);
        logic [7:0] d;
        sel(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, d);
            chk8(req, d, exp_mem[11'(a[10:0] + 11'(k))]);
        end
        desel();
    endtask

    // R3 and R1: frame open across reset release is ignored; reset state
    task automatic t_startup();
        logic [7:0] d;
        chk8("R1 oe after reset", {7'd0, spi_miso_oe}, 8'h00);
        oe_seen = 1'b0;
        xfer(8'h05, d); xfer(8'h00, d);
        chk8("R3 no output before first select fall", {7'd0, oe_seen}, 8'h00);
        desel();
        rdsr(d);
        chk8("R1 status after reset", d, 8'h00);
    endtask

    // R5: latch set and clear need an exact eight-bit frame
    task automatic t_latch();
        logic [7:0] d;
        cmd1(8'h06); rdsr(d); chk8("R5 latch set", d, 8'h02);
        cmd1(8'h04); rdsr(d); chk8("R5 latch clear", d, 8'h00);
        sel(); xfer(8'h06, d); xbits(8'h00, 1, d); desel();
        rdsr(d); chk8("R5 nine bits ignored", d, 8'h00);
        sel(); xbits(8'h06, 7, d); desel();
        rdsr(d); chk8("R5 seven bits ignored", d, 8'h00);
        wr_mem(16'h0010, 1, 8'hEE, 1'b0);
        wait_ready();
        rdsr(d); chk8("R6 write refused without latch", d, 8'h00);
    endtask

    // R6 R8 R4: byte write, busy timing, readback in one clock mode
    task automatic t_write_read(input logic m3, input logic [15:0] a, input logic [7:0] seed);
        logic [7:0] d;
        mode3 = m3;
        cmd1(8'h06);
        wr_mem(a, 4, seed, 1'b1);
        rdsr(d); chk8("R8 busy with latch during write", d, 8'h03);
        wait_ready();
        rdsr(d); chk8("R8 busy and latch clear after write", d, 8'h00);
        rd_chk(a, 4, m3 ? "R4 mode 3 readback" : "R4 mode 0 readback");
        mode3 = 1'b0;
    endtask

    // R6: page wrap with replacement
    task automatic t_page_wrap();
        cmd1(8'h06);
        wr_mem(16'h02FC, 40, 8'h40, 1'b1);
        wait_ready();
        rd_chk(16'h02E0, 32, "R6 page wrap");
    endtask

    // R7: partial final byte discards the write
    task automatic t_bad_count();
        logic [7:0] d;
        cmd1(8'h06);
        sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h00, d);
        xfer(8'hC3, d); xbits(8'hFF, 3, d); desel();
        rdsr(d); chk8("R7 no busy and latch kept", d, 8'h02);
        cmd1(8'h04);
        rd_chk(16'h0000, 1, "R7 array unchanged");
    endtask

    // R11: commands during busy are ignored
    task automatic t_busy_block();
        logic [7:0] d;
        cmd1(8'h06);
        wr_mem(16'h0050, 1, 8'h11, 1'b1);
        sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h50, d); xfer(8'h00, d); desel();
        chk8("R11 no read output while busy", {7'd0, oe_seen}, 8'h00);
        cmd1(8'h06);
        sel(); xfer(8'h02, d); xfer(8'h00, d); desel();
        wait_ready();
        rdsr(d); chk8("R11 latch not set during busy", d, 8'h00);
        rd_chk(16'h0050, 1, "R11 write during busy ignored");
    endtask

    // R10: repeated status across the end of busy
    task automatic t_status_stream();
        logic [7:0] d, prev;
        bit ok;
        cmd1(8'h06);
        wr_mem(16'h0070, 1, 8'h5A, 1'b1);
        sel(); xfer(8'h05, d);
        prev = 8'h03; ok = 1'b1;
        for (int k = 0; k < 14; k++) begin
            xfer(8'h00, d);
            if (k == 0) chk8("R10 first status busy", d, 8'h03);
            if (!(d == 8'h03 || d == 8'h00) || (prev == 8'h00 && d != 8'h00)) ok = 1'b0;
            prev = d;
        end
        desel();
        chk8("R10 stream consistent", {7'd0, ok}, 8'h01);
        chk8("R10 last status idle", prev, 8'h00);
        rd_chk(16'h0070, 1, "R10 write completed");
    endtask

    // R9: sequential read wraps at top of array
    task automatic t_read_wrap();
        cmd1(8'h06); wr_mem(16'h07FE, 2, 8'hA0, 1'b1); wait_ready();
        cmd1(8'h06); wr_mem(16'h0000, 2, 8'hB0, 1'b1); wait_ready();
        rd_chk(16'h07FE, 4, "R9 wrap to zero");
    endtask

    // R12 and R2: unknown opcode and abandoned frame
    task automatic t_unknown();
        logic [7:0] d;
        sel(); xfer(8'hA5, d); xfer(8'h05, d); xfer(8'h00, d); desel();
        chk8("R12 unknown opcode no output", {7'd0, oe_seen}, 8'h00);
        sel(); xfer(8'hFF, d); xfer(8'h06, d); desel();
        rdsr(d); chk8("R12 rest of frame ignored", d, 8'h00);
        sel(); xfer(8'h05, d); xbits(8'h00, 4, d); desel();
        chk8("R2 oe low after select rise", {7'd0, spi_miso_oe}, 8'h00);
        rdsr(d); chk8("R2 next frame served", d, 8'h00);
    endtask

    // R13: block protect
    task automatic t_protect();
        logic [7:0] d;
        cmd1(8'h06); wr_mem(16'h0700, 1, 8'h77, 1'b1); wait_ready();
        cmd1(8'h06); wrsr(8'h04);
        rdsr(d); chk8("R13 status write busy", d, 8'h07);
        wait_ready();
        rdsr(d); chk8("R13 protect bits stored", d, 8'h04);
        cmd1(8'h06); wr_mem(16'h0700, 1, 8'h99, 1'b0);
        rdsr(d); chk8("R13 guarded write discarded", d, 8'h06);
        wr_mem(16'h0100, 2, 8'h31, 1'b1); wait_ready();
        rd_chk(16'h0700, 1, "R13 guarded byte kept");
        rd_chk(16'h0100, 2, "R13 open area written");
        cmd1(8'h06); wrsr(8'h00); wait_ready();
        rdsr(d); chk8("R13 protect cleared", d, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; spi_cs_n = 1'b0; spi_sck = 1'b0; spi_mosi = 1'b0; oe_seen = 1'b0;
        wclk(10);
        rst_n = 1'b1;
        wclk(10);
        t_startup();
        t_latch();
        t_write_read(1'b0, 16'h0123, 8'h3C);
        t_write_read(1'b1, 16'h0456, 8'hC5);
        t_page_wrap();
        t_bad_count();
        t_busy_block();
        t_status_stream();
        t_read_wrap();
        t_unknown();
        t_protect();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule